// File: doc/BRIEF.md
# Synchronous DRAM Device Model

This block is a synthesizable, clock-accurate model of a four-bank synchronous DRAM with a 16-bit data path, scaled down so that it fits in simulation. On every rising clock edge it decodes one command from the active-low chip select, row strobe, column strobe and write enable inputs. It keeps a programmable mode register and tracks which row is open in each bank. During a burst it produces the column addresses itself. Read data comes back after the programmed CAS latency, and two per-byte mask inputs act on both reads and writes.

Storage is a small internal array. The 12-bit row address is folded into a few stored rows, and each page keeps a parameterised number of columns (16 by default). The data bus is split into a data-out port and a per-byte output-enable port instead of a bidirectional pin, so a surrounding bench or wrapper can drive a shared bus from it. A controller under test connects to it the same way it would connect to a real device.

Top module: `sdram_model`

## Requirements
- R1: After reset no output byte is enabled, the error flag is low and all four banks are closed. The mode is burst length 1, sequential order, CAS latency 2.
- R2: A command is {rasN,casN,weN}, taken only when csN is low: 000 mode set, 001 refresh (no effect), 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no operation. While csN is high the inputs are ignored and a running burst carries on.
- R3: Activate opens bank `ba` with the row on `addr`. The stored row is the XOR fold of the 12 row bits into 2 bits (bit i goes to stored bit i mod 2). Precharge closes bank `ba`, or every bank when addr[10] is 1.
- R4: Mode set loads addr[2:0] as the burst length code (000=1, 001=2, 010=4, 011=8, 111=full page of 2^COL_W columns, any other code=1), addr[3] as the order (1=interleaved), and addr[6:4] as the latency (011 gives 3, any other value gives 2).
- R5: A read beat addressed at rising edge t drives its word on dqOut with both enables high, from edge t+CL-1 until the next edge.
- R6: In sequential order, beat k of a burst of length L that starts at column s uses column (s with its low log2(L) bits replaced by (s+k) mod L). A full page wraps around the page and runs until it is stopped.
- R7: In interleaved order, beat k uses s with its low log2(L) bits XORed with k. A full page always runs in sequential order.
- R8: A write stores dqIn on every beat. For each byte, dqm high on the same edge leaves that byte of memory unchanged (dqm[0] covers bits 7:0, dqm[1] covers bits 15:8).
- R9: For each byte, dqm high at edge e turns off the enable of the read byte that is driven after edge e+1.
- R10: A new accepted read or write cuts the running burst short. A burst stop, or a precharge that hits the burst's bank, ends it with no beat on that edge.
- R11: When addr[10] is 1 on a read or write, the bank closes on the burst's final beat. A burst that is cut short or runs in full-page mode does not close the bank.
- R12: A read or write to a closed bank raises protoErr for the one cycle after that edge. The access changes neither memory nor a running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe command bit |
| casN | input | 1 | Column strobe command bit |
| weN | input | 1 | Write enable command bit |
| ba | input | 2 | Bank select |
| addr | input | 12 | Shared row / column / mode address |
| dqm | input | 2 | Per-byte mask |
| dqIn | input | 16 | Write data |
| dqOut | output | 16 | Read data |
| dqOe | output | 2 | Per-byte read data enable |
| protoErr | output | 1 | Access to a closed bank in the previous cycle |

## Verification
Each burst length is tried with a start column that is not aligned, so that the wrap inside the aligned block (sequential) can be told apart from the XOR walk (interleaved) and from a plain increment. Both latencies are used, with and without masks on the read side and on the write side, so that a two-cycle read mask latency can be told apart from a same-cycle one. Interrupts, stops, precharges that hit and miss the burst bank, auto-precharge on a completed burst and on a cut-short burst, accesses to closed banks and deselected cycles are placed in the middle of bursts to show which of them end the burst. A long random stretch of mixed commands, masks and banks then runs against the reference model, which is compared on every clock.

// File: rtl/sdram_model_pkg.sv
package sdram_model_pkg;

  // command code as {rasN, casN, weN}
  typedef enum logic [2:0] {
    CMD_MODE  = 3'b000,
    CMD_REFR  = 3'b001,
    CMD_PRE   = 3'b010,
    CMD_ACT   = 3'b011,
    CMD_WRITE = 3'b100,
    CMD_READ  = 3'b101,
    CMD_STOP  = 3'b110,
    CMD_NOP   = 3'b111
  } cmdE;

  // strobes from the control section to the datapath
  typedef struct packed {
    logic rdEn;
    logic wrEn;
  } memStrobeT;

endpackage

// File: rtl/sdram_model_ctrl.sv
module sdram_model_ctrl
  import sdram_model_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BA_W     = 2,
  parameter int ROW_KEEP = 2,
  parameter int COL_W    = 4,
  localparam int BANKS   = 1 << BA_W,
  localparam int IDX_W   = BA_W + ROW_KEEP + COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output memStrobeT         strobe,
  output logic [IDX_W-1:0]  memIdx,
  output logic              cl3,
  output logic              protoErr,
  output logic              burstActive,
  output logic [BANKS-1:0]  rowOpen
);

  localparam int AP_BIT = 10;

  // bank row state
  logic [ROW_KEEP-1:0] openRow [BANKS];

  // mode register fields
  logic [COL_W-1:0] modeMask;
  logic             modeFull;
  logic             modeInter;

  // running burst
  logic [BA_W-1:0]  bBank;
  logic [COL_W-1:0] bStart;
  logic [COL_W-1:0] bBeat;
  logic [COL_W-1:0] bMask;
  logic             bWr;
  logic             bFull;
  logic             bInter;
  logic             bAp;

  cmdE              cmd;
  logic             isAccess;
  logic             accessOk;
  logic             preHitsBurst;
  logic             contBeat;
  logic             lastBeat;
  logic             closeAp;
  logic [BA_W-1:0]  bankSel;
  logic [COL_W-1:0] colSel;

  function automatic logic [COL_W-1:0] beatCol(
    input logic [COL_W-1:0] s,
    input logic [COL_W-1:0] k,
    input logic [COL_W-1:0] m,
    input logic             il
  );
    if (il) return (s & ~m) | ((s ^ k) & m);
    return (s & ~m) | ((s + k) & m);
  endfunction

  function automatic logic [ROW_KEEP-1:0] foldRow(input logic [ADDR_W-1:0] r);
    logic [ROW_KEEP-1:0] acc;
    acc = '0;
    for (int i = 0; i < ADDR_W; i++) acc[i % ROW_KEEP] = acc[i % ROW_KEEP] ^ r[i];
    return acc;
  endfunction

  function automatic logic [COL_W-1:0] lenMask(input logic [2:0] code);
    case (code)
      3'd1:    return COL_W'(1);
      3'd2:    return COL_W'(3);
      3'd3:    return COL_W'(7);
      3'd7:    return '1;
      default: return '0;
    endcase
  endfunction

  always_comb begin
    cmd          = csN ? CMD_NOP : cmdE'({rasN, casN, weN});
    isAccess     = (cmd == CMD_READ) || (cmd == CMD_WRITE);
    accessOk     = isAccess && rowOpen[ba];
    preHitsBurst = (cmd == CMD_PRE) && (addr[AP_BIT] || (ba == bBank));
    contBeat     = burstActive && !accessOk && (cmd != CMD_STOP) && !preHitsBurst;
  end

  always_comb begin
    strobe   = '0;
    bankSel  = bBank;
    colSel   = '0;
    lastBeat = 1'b0;
    closeAp  = 1'b0;
    if (accessOk) begin
      strobe.rdEn = (cmd == CMD_READ);
      strobe.wrEn = (cmd == CMD_WRITE);
      bankSel     = ba;
      colSel      = addr[COL_W-1:0];
      lastBeat    = (modeMask == '0);
      closeAp     = lastBeat && addr[AP_BIT];
    end else if (contBeat) begin
      strobe.rdEn = !bWr;
      strobe.wrEn = bWr;
      colSel      = beatCol(bStart, bBeat, bMask, bInter);
      lastBeat    = !bFull && (bBeat == bMask);
      closeAp     = lastBeat && bAp;
    end
    memIdx = {bankSel, openRow[bankSel], colSel};
  end

  // burst sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstActive <= 1'b0;
      bBank       <= '0;
      bStart      <= '0;
      bBeat       <= '0;
      bMask       <= '0;
      bWr         <= 1'b0;
      bFull       <= 1'b0;
      bInter      <= 1'b0;
      bAp         <= 1'b0;
      protoErr    <= 1'b0;
    end else begin
      protoErr <= isAccess && !rowOpen[ba];
      if (accessOk) begin
        bBank       <= ba;
        bStart      <= addr[COL_W-1:0];
        bBeat       <= COL_W'(1);
        bMask       <= modeMask;
        bFull       <= modeFull;
        bInter      <= modeInter && !modeFull;
        bAp         <= addr[AP_BIT];
        bWr         <= (cmd == CMD_WRITE);
        burstActive <= !lastBeat;
      end else if (contBeat) begin
        bBeat <= bBeat + COL_W'(1);
        if (lastBeat) burstActive <= 1'b0;
      end else begin
        burstActive <= 1'b0;
      end
    end
  end

  // bank state and mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowOpen   <= '0;
      for (int b = 0; b < BANKS; b++) openRow[b] <= '0;
      modeMask  <= '0;
      modeFull  <= 1'b0;
      modeInter <= 1'b0;
      cl3       <= 1'b0;
    end else begin
      if (closeAp) rowOpen[bankSel] <= 1'b0;
      case (cmd)
        CMD_ACT: begin
          rowOpen[ba] <= 1'b1;
          openRow[ba] <= foldRow(addr);
        end
        CMD_PRE: begin
          if (addr[AP_BIT]) rowOpen <= '0;
          else rowOpen[ba] <= 1'b0;
        end
        CMD_MODE: begin
          modeMask  <= lenMask(addr[2:0]);
          modeFull  <= (addr[2:0] == 3'd7);
          modeInter <= addr[3];
          cl3       <= (addr[6:4] == 3'd3);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sdram_model_data.sv
module sdram_model_data
  import sdram_model_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8,
  localparam int NB    = DATA_W / 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobeT         strobe,
  input  logic [IDX_W-1:0]  memIdx,
  input  logic              cl3,
  input  logic [NB-1:0]     dqm,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic [NB-1:0]     dqOe
);

  logic [DATA_W-1:0] mem [DEPTH];

  // read latency pipeline
  logic              s0Valid;
  logic [DATA_W-1:0] s0Data;
  logic              s1Valid;
  logic [DATA_W-1:0] s1Data;
  logic [NB-1:0]     dqmDly;
  logic              srcValid;
  logic [DATA_W-1:0] srcData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobe.wrEn) begin
      for (int b = 0; b < NB; b++)
        if (!dqm[b]) mem[memIdx][b*8 +: 8] <= dqIn[b*8 +: 8];
    end
  end

  always_comb begin
    srcValid = cl3 ? s1Valid : s0Valid;
    srcData  = cl3 ? s1Data  : s0Data;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s0Valid <= 1'b0;
      s0Data  <= '0;
      s1Valid <= 1'b0;
      s1Data  <= '0;
      dqmDly  <= '0;
      dqOut   <= '0;
      dqOe    <= '0;
    end else begin
      s0Valid <= strobe.rdEn;
      if (strobe.rdEn) s0Data <= mem[memIdx];
      s1Valid <= s0Valid;
      s1Data  <= s0Data;
      dqmDly  <= dqm;
      dqOut   <= srcData;
      for (int b = 0; b < NB; b++) dqOe[b] <= srcValid && !dqmDly[b];
    end
  end

endmodule

// File: rtl/sdram_model.sv
module sdram_model
  import sdram_model_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BA_W     = 2,
  parameter int DATA_W   = 16,
  parameter int ROW_KEEP = 2,
  parameter int COL_W    = 4,
  localparam int NB      = DATA_W / 8,
  localparam int BANKS   = 1 << BA_W,
  localparam int IDX_W   = BA_W + ROW_KEEP + COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NB-1:0]     dqm,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic [NB-1:0]     dqOe,
  output logic              protoErr
);

  memStrobeT        strobe;
  logic [IDX_W-1:0] memIdx;
  logic             cl3;
  logic             burstActive;
  logic [BANKS-1:0] rowOpen;

  sdram_model_ctrl #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .ROW_KEEP(ROW_KEEP), .COL_W(COL_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .strobe(strobe), .memIdx(memIdx), .cl3(cl3),
    .protoErr(protoErr), .burstActive(burstActive), .rowOpen(rowOpen)
  );

  sdram_model_data #(
    .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memIdx(memIdx), .cl3(cl3),
    .dqm(dqm), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

endmodule

// File: rtl/sdram_model_checker.sv
module sdram_model_checker
  import sdram_model_pkg::*;
#(
  parameter int BA_W = 2,
  parameter int NB   = 2,
  localparam int BANKS = 1 << BA_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             rasN,
  input logic             casN,
  input logic             weN,
  input logic [NB-1:0]    dqm,
  input logic [NB-1:0]    dqOe,
  input logic             protoErr,
  input logic             burstActive,
  input logic [BANKS-1:0] rowOpen,
  input memStrobeT        strobe,
  input logic [BA_W-1:0]  memBank
);

  // R12: the error flag follows a read or write command on the previous edge
  a_r12_err_after_access: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> $past(!csN && rasN && !casN));

  // R2: a deselected cycle never produces an error
  a_r2_deselect_no_err: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !protoErr);

  // R3: the datapath is only strobed for a bank that is open
  a_r3_access_open_bank: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn || strobe.wrEn) |-> rowOpen[memBank]);

  // R10: a burst stop leaves no burst running
  a_r10_stop_ends: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && rasN && casN && !weN) |=> !burstActive);

  // R9: an enabled read byte was not masked two edges earlier
  for (genvar b = 0; b < NB; b++) begin : gLane
    a_r9_read_mask: assert property (@(posedge clk) disable iff (!rstN)
      dqOe[b] |-> !$past(dqm[b], 2));
  end

endmodule

bind sdram_model sdram_model_checker #(.BA_W(BA_W), .NB(NB)) uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
  .dqm(dqm), .dqOe(dqOe), .protoErr(protoErr), .burstActive(burstActive),
  .rowOpen(rowOpen), .strobe(strobe), .memBank(memIdx[IDX_W-1 -: BA_W])
);

// File: tb/sdram_model_test.sv
module sdram_model_test;

  localparam int PAGE = 16;
  localparam logic [2:0] C_MODE = 3'b000, C_REFR = 3'b001, C_PRE = 3'b010,
    C_ACT = 3'b011, C_WR = 3'b100, C_RD = 3'b101, C_STOP = 3'b110, C_NOP = 3'b111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [1:0]  dqm = '0;
  logic [15:0] dqIn = '0;
  logic [15:0] dqOut;
  logic [1:0]  dqOe;
  logic        protoErr;

  sdram_model uut (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .dqm(dqm), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe),
    .protoErr(protoErr)
  );

  int    nChk = 0;
  int    nBad = 0;
  string phase = "R1 reset";

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int          mLen, mCl;
  bit          mFull, mInter;
  bit          mOpen [4];
  int          mRow [4];
  logic [15:0] mMem [int];
  bit          bAct, bWr, bAp, bFull, bInter;
  int          bBank, bStart, bK, bLen;
  bit          ringV [8];
  logic [15:0] ringD [8];
  int          edgeN;
  logic [1:0]  dqmPrev, expOe;
  logic [15:0] expD;
  bit          expErr;

  function automatic int ordCol(int s, int k, int len, bit il);
    int m = len - 1;
    int base = s & ~m;
    if (il) return base | ((s ^ k) & m);
    return base | ((s + k) & m);
  endfunction

  function automatic int fold(int r);
    int f = 0;
    for (int i = 0; i < 12; i++) f = f ^ (((r >> i) & 1) << (i % 2));
    return f;
  endfunction

  function automatic int memKey(int b, int r, int c);
    return ((b * 4) + fold(r)) * PAGE + c;
  endfunction

  always @(posedge clk) begin : model
    int c, col, k, slot;
    logic [15:0] w;
    if (!rstN) begin
      mLen = 1; mCl = 2; mFull = 0; mInter = 0;
      for (int i = 0; i < 4; i++) begin mOpen[i] = 0; mRow[i] = 0; end
      for (int i = 0; i < 8; i++) ringV[i] = 0;
      mMem.delete();
      bAct = 0; edgeN = 0; dqmPrev = 0; expOe = 0; expD = 0; expErr = 0;
    end else begin
      edgeN++;
      expErr = 0;
      c = csN ? 7 : int'({rasN, casN, weN});
      if (c == 5 || c == 4) begin
        if (mOpen[ba]) begin
          bAct = 1; bWr = (c == 4); bBank = ba; bStart = addr % PAGE; bK = 0;
          bLen = mLen; bFull = mFull; bInter = mInter && !mFull; bAp = addr[10];
        end else expErr = 1;
      end else if (c == 6) bAct = 0;
      else if (c == 2 && bAct && (addr[10] || ba == bBank)) bAct = 0;
      if (bAct) begin
        col = ordCol(bStart, bK, bLen, bInter);
        k = memKey(bBank, mRow[bBank], col);
        w = mMem.exists(k) ? mMem[k] : 16'h0;
        if (bWr) begin
          if (!dqm[0]) w[7:0] = dqIn[7:0];
          if (!dqm[1]) w[15:8] = dqIn[15:8];
          mMem[k] = w;
        end else begin
          slot = (edgeN + mCl - 1) % 8;
          ringV[slot] = 1; ringD[slot] = w;
        end
        bK++;
        if (!bFull && bK == bLen) begin
          bAct = 0;
          if (bAp) mOpen[bBank] = 0;
        end
      end
      if (c == 3) begin mOpen[ba] = 1; mRow[ba] = addr; end
      if (c == 2) begin
        if (addr[10]) for (int i = 0; i < 4; i++) mOpen[i] = 0;
        else mOpen[ba] = 0;
      end
      if (c == 0) begin
        case (addr[2:0])
          3'd1: mLen = 2;
          3'd2: mLen = 4;
          3'd3: mLen = 8;
          3'd7: mLen = PAGE;
          default: mLen = 1;
        endcase
        mFull = (addr[2:0] == 3'd7);
        mInter = addr[3];
        mCl = (addr[6:4] == 3'd3) ? 3 : 2;
      end
      slot = edgeN % 8;
      expOe = ringV[slot] ? ~dqmPrev : 2'b00;
      expD = ringD[slot];
      ringV[slot] = 0;
      dqmPrev = dqm;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check(dqOe == expOe, {phase, " (R5 R9 byte enables)"}, dqOe, expOe);
      for (int b = 0; b < 2; b++)
        if (expOe[b] && dqOe[b])
          check(dqOut[b*8 +: 8] == expD[b*8 +: 8], {phase, " (R6 R7 R8 read data)"},
                dqOut[b*8 +: 8], expD[b*8 +: 8]);
      check(protoErr == expErr, {phase, " (R12 error flag)"}, protoErr, expErr);
    end
  end

  // ---------------- stimulus ----------------
  task automatic op(input logic [2:0] c, input int b = 0, input int a = 0,
                    input logic [1:0] m = 2'b00, input logic [15:0] d = 16'h0);
    csN = 1'b0; {rasN, casN, weN} = c; ba = b[1:0]; addr = a[11:0]; dqm = m; dqIn = d;
    @(negedge clk);
  endtask

  task automatic nop(input int n);
    repeat (n) op(C_NOP);
  endtask

  task automatic desel(input logic [2:0] c, input int a);
    csN = 1'b1; {rasN, casN, weN} = c; addr = a[11:0]; dqm = 2'b00;
    @(negedge clk);
  endtask

  function automatic int modeWord(int code, int il, int cl);
    return code | (il << 3) | (cl << 4);
  endfunction

  bit done = 0;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(dqOe == 2'b00, "R1 reset enables", dqOe, 0);
    check(protoErr == 1'b0, "R1 reset error", protoErr, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: all banks closed after reset
    op(C_RD, 0, 2);
    check(protoErr == 1'b1, "R1 bank closed after reset", protoErr, 1);
    // R1 / R5: burst length 1, latency 2 by default
    phase = "R1 R5 default mode";
    op(C_ACT, 0, 12'h005);
    op(C_WR, 0, 2, 2'b00, 16'h1234);
    op(C_RD, 0, 2);
    nop(1);
    check(dqOe == 2'b11, "R5 default latency enable", dqOe, 3);
    check(dqOut == 16'h1234, "R5 default latency data", dqOut, 16'h1234);
    nop(1);
    check(dqOe == 2'b00, "R1 single beat", dqOe, 0);

    // R4 R6: sequential length 4, unaligned start
    phase = "R4 R6 sequential 4";
    op(C_MODE, 0, modeWord(2, 0, 2));
    op(C_WR, 0, 5, 2'b00, 16'hA001); op(C_NOP, 0, 0, 2'b00, 16'hA002);
    op(C_NOP, 0, 0, 2'b00, 16'hA003); op(C_NOP, 0, 0, 2'b00, 16'hA004);
    op(C_RD, 0, 5); nop(6);
    op(C_RD, 0, 4); nop(6);

    // R7: interleaved length 8, latency 3
    phase = "R4 R7 interleaved 8 CL3";
    op(C_MODE, 0, modeWord(3, 1, 3));
    op(C_ACT, 1, 12'h0F3);
    op(C_WR, 1, 0, 2'b00, 16'h0100);
    for (int i = 1; i < 8; i++) op(C_NOP, 0, 0, 2'b00, 16'h0100 + 16'(i));
    op(C_RD, 1, 3); nop(10);
    op(C_RD, 1, 6); nop(10);

    // R6 R7: full page wraps and ignores the interleave bit
    phase = "R6 R7 full page";
    op(C_MODE, 0, modeWord(7, 1, 2));
    op(C_WR, 1, 14, 2'b00, 16'h5000);
    for (int i = 1; i < 18; i++) op(C_NOP, 0, 0, 2'b00, 16'h5000 + 16'(i));
    op(C_STOP); nop(2);
    op(C_RD, 1, 9); nop(19); op(C_STOP); nop(4);

    // R8 R9: byte masks on writes and reads
    phase = "R8 R9 byte masks";
    op(C_MODE, 0, modeWord(2, 0, 2));
    op(C_WR, 2'd0, 8, 2'b01, 16'hBEEF); op(C_NOP, 0, 0, 2'b10, 16'hCAFE);
    op(C_NOP, 0, 0, 2'b11, 16'hDEAD); op(C_NOP, 0, 0, 2'b00, 16'hF00D);
    op(C_RD, 0, 8, 2'b00); op(C_NOP, 0, 0, 2'b10); op(C_NOP, 0, 0, 2'b01);
    op(C_NOP, 0, 0, 2'b00); nop(4);
    op(C_MODE, 0, modeWord(2, 0, 3));
    op(C_RD, 0, 8, 2'b11); op(C_NOP, 0, 0, 2'b00); op(C_NOP, 0, 0, 2'b01); nop(6);

    // R10: interrupts, stop, precharge hit and miss
    phase = "R10 burst endings";
    op(C_MODE, 0, modeWord(3, 0, 2));
    op(C_ACT, 2, 12'h3C0);
    op(C_WR, 2, 0, 2'b00, 16'h7700);
    for (int i = 1; i < 8; i++) op(C_NOP, 0, 0, 2'b00, 16'h7700 + 16'(i));
    op(C_RD, 2, 0); nop(1); op(C_RD, 2, 4); nop(2); op(C_STOP); nop(4);
    op(C_RD, 2, 1); nop(1); op(C_PRE, 3, 0); nop(1); op(C_PRE, 2, 0); nop(4);
    op(C_RD, 2, 0);
    check(protoErr == 1'b1, "R10 R3 precharged bank closed", protoErr, 1);

    // R11: auto-precharge on a completed burst only
    phase = "R11 auto precharge";
    op(C_MODE, 0, modeWord(2, 0, 2));
    op(C_ACT, 3, 12'h001);
    op(C_RD, 3, 12'h400); nop(2);
    op(C_RD, 3, 0);
    check(protoErr == 1'b0, "R11 bank open until final beat", protoErr, 0);
    op(C_RD, 3, 12'h401); nop(3);
    op(C_RD, 3, 0);
    check(protoErr == 1'b1, "R11 bank closed after final beat", protoErr, 1);
    op(C_ACT, 3, 12'h001);
    op(C_RD, 3, 12'h400); op(C_RD, 3, 2); nop(4);
    op(C_RD, 3, 0);
    check(protoErr == 1'b0, "R11 interrupted burst keeps bank open", protoErr, 0);
    nop(6);

    // R12 R2: closed-bank access and deselect during a burst
    phase = "R12 R2 ignored accesses";
    op(C_PRE, 1, 0);
    op(C_RD, 0, 8); op(C_WR, 1, 3, 2'b00, 16'hFFFF);
    check(protoErr == 1'b1, "R12 closed bank write flagged", protoErr, 1);
    desel(C_STOP, 0); desel(C_WR, 0); nop(4);
    check(protoErr == 1'b0, "R2 deselect no error", protoErr, 0);
    op(C_ACT, 1, 12'h0F3);
    op(C_RD, 1, 3); nop(6);

    // R3: precharge-all, row fold and row separation
    phase = "R3 rows";
    op(C_PRE, 0, 12'h400);
    op(C_RD, 0, 0);
    check(protoErr == 1'b1, "R3 precharge all", protoErr, 1);
    op(C_ACT, 0, 12'h006);
    op(C_RD, 0, 2); nop(6);
    op(C_ACT, 0, 12'h00C);
    op(C_RD, 0, 8); nop(6);
    op(C_REFR); nop(2);

    // random mixed traffic in two modes
    for (int pass = 0; pass < 2; pass++) begin
      phase = pass == 0 ? "R2 R6 R7 R10 R12 random CL3" : "R2 R6 R10 R11 random CL2";
      op(C_STOP); nop(4);
      op(C_MODE, 0, pass == 0 ? modeWord(2, 1, 3) : modeWord(1, 0, 2));
      for (int i = 0; i < 400; i++) begin
        int r = int'($urandom % 10);
        int b = int'($urandom % 4);
        int a = int'($urandom % 4096);
        logic [1:0] m = 2'($urandom);
        logic [15:0] d = 16'($urandom);
        case (r)
          0, 1: op(C_ACT, b, a, m, d);
          2, 3: op(C_RD, b, a, m, d);
          4, 5: op(C_WR, b, a, m, d);
          6: op(C_PRE, b, ($urandom % 4 == 0) ? a : (a & 12'h3FF), m, d);
          7: op(C_STOP, b, a, m, d);
          8: desel(3'($urandom), a);
          default: op(C_NOP, b, a, m, d);
        endcase
      end
      op(C_STOP); nop(6);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule